// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a 32-bit processor whose instructions are all one word long. Each cycle it forms three candidate addresses from the current PC and the low 26 bits of the instruction word. The first is the sequential address, PC plus four. The second is a branch target: a signed, word-scaled 16-bit offset added to that sequential address. The third is a region jump target: the top four bits of the sequential address with a 26-bit word index placed below them. A register-supplied address can also be selected for indirect jumps.

The decoder supplies three flags. The comparator supplies a branch-taken flag, the decoder flags a direct jump, and it flags a register-indirect jump together with the register value. The unit picks the next PC by fixed priority and shows it on a combinational output. It loads that value into the PC on the next rising clock edge, unless a stall holds the PC or a synchronous reset loads the reset vector. The opcode bits are decoded outside the block, so only the low 26 instruction bits enter it.

Top module: `next_pc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_o` is loaded with the parameter `RESET_VEC` (default 0x0040_0000). Reset takes precedence over `stall` and over every select flag.
- R2: `seq_o` equals `pc_o + 4`, taken modulo 2^32, so 0xFFFF_FFFC wraps to 0x0000_0000.
- R3: `br_target_o` equals `seq_o + (sign_extend(instr_i[15:0]) << 2)`. Bit 15 is the sign, so both forward and backward offsets are reached. Field value 0x8000 moves the target back by 0x20000 bytes and 0x7FFF moves it forward by 0x1FFFC bytes.
- R4: `jmp_target_o` equals `{seq_o[31:28], instr_i[25:0], 2'b00}`. The region bits come from the incremented PC, so a jump at 0x0FFF_FFFC lands in region 0x1.
- R5: `npc_o` is selected by priority. It is `jr_addr_i` when `jr_i` is 1. Otherwise it is `jmp_target_o` when `jmp_i` is 1. Otherwise it is `br_target_o` when `br_taken_i` is 1. Otherwise it is `seq_o`.
- R6: At each rising edge with `rst` and `stall` both low, `pc_o` takes the value `npc_o` had before that edge.
- R7: At a rising edge with `stall` high and `rst` low, `pc_o` keeps its value. `npc_o` still shows the selected target during the stall.
- R8: `npc_o` and the three candidate outputs depend only on the current `pc_o` and the inputs of the same cycle, with no added cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold the PC this cycle |
| instr_i | input | 26 | Low 26 bits of the current instruction word |
| br_taken_i | input | 1 | Branch condition met |
| jmp_i | input | 1 | Direct region jump |
| jr_i | input | 1 | Register-indirect jump |
| jr_addr_i | input | 32 | Address for the register-indirect jump |
| pc_o | output | 32 | Current program counter (registered) |
| seq_o | output | 32 | PC + 4 |
| br_target_o | output | 32 | PC-relative branch target |
| jmp_target_o | output | 32 | Region jump target |
| npc_o | output | 32 | Selected next PC |

## Verification
The branch path is tried with small positive offsets, a minus-one offset, and both extremes of the signed field. The two extremes separate true sign extension from zero extension, and they expose a missing or doubled word shift. Jumps are issued from three different regions, one of them the last word before a region boundary. That case separates region bits taken from the incremented PC from region bits taken from the jump's own address. Flag combinations that assert several selects at once pin down the priority order. Stall, reset-with-stall and PC wrap-around then cover the register update rules.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    SEL_SEQ = 2'd0,
    SEL_BR  = 2'd1,
    SEL_JMP = 2'd2,
    SEL_REG = 2'd3
  } npc_sel_e;
endpackage

// File: rtl/npc_fields.sv
module npc_fields #(
  parameter int XLEN     = 32,
  parameter int OFF_W    = 16,
  parameter int JFIELD_W = 26,
  parameter int ALIGN    = 2
) (
  input  logic [JFIELD_W-1:0] instr_i,
  output logic [XLEN-1:0]     off_bytes_o,
  output logic [JFIELD_W+ALIGN-1:0] jidx_bytes_o
);
  localparam int EXT_W = XLEN - OFF_W - ALIGN;

  logic [OFF_W-1:0] off_raw;

  always_comb begin
    off_raw      = instr_i[OFF_W-1:0];
    // signed offset, scaled from words to bytes
    off_bytes_o  = {{EXT_W{off_raw[OFF_W-1]}}, off_raw, {ALIGN{1'b0}}};
    jidx_bytes_o = {instr_i, {ALIGN{1'b0}}};
  end
endmodule

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int XLEN     = 32,
  parameter int JFIELD_W = 26,
  parameter int ALIGN    = 2
) (
  input  logic [XLEN-1:0]           pc_i,
  input  logic [XLEN-1:0]           off_bytes_i,
  input  logic [JFIELD_W+ALIGN-1:0] jidx_bytes_i,
  output logic [XLEN-1:0]           seq_o,
  output logic [XLEN-1:0]           br_o,
  output logic [XLEN-1:0]           jmp_o
);
  localparam int REGION_W = XLEN - JFIELD_W - ALIGN;
  localparam logic [XLEN-1:0] STEP = XLEN'(1 << ALIGN);

  logic [XLEN-1:0] seq;

  always_comb begin
    seq   = pc_i + STEP;
    seq_o = seq;
    br_o  = seq + off_bytes_i;
  end

  generate
    if (REGION_W > 0) begin : g_region
      assign jmp_o = {seq[XLEN-1 -: REGION_W], jidx_bytes_i};
    end else begin : g_flat
      assign jmp_o = jidx_bytes_i[XLEN-1:0];
    end
  endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            jr_i,
  input  logic            jmp_i,
  input  logic            br_i,
  input  logic [XLEN-1:0] seq_i,
  input  logic [XLEN-1:0] br_tgt_i,
  input  logic [XLEN-1:0] jmp_tgt_i,
  input  logic [XLEN-1:0] reg_tgt_i,
  output logic [XLEN-1:0] npc_o
);
  npc_sel_e sel;

  always_comb begin
    if (jr_i)       sel = SEL_REG;
    else if (jmp_i) sel = SEL_JMP;
    else if (br_i)  sel = SEL_BR;
    else            sel = SEL_SEQ;
  end

  always_comb begin
    unique case (sel)
      SEL_REG: npc_o = reg_tgt_i;
      SEL_JMP: npc_o = jmp_tgt_i;
      SEL_BR:  npc_o = br_tgt_i;
      default: npc_o = seq_i;
    endcase
  end
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit #(
  parameter int XLEN     = 32,
  parameter int OFF_W    = 16,
  parameter int JFIELD_W = 26,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0040_0000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stall,
  input  logic [JFIELD_W-1:0] instr_i,
  input  logic                br_taken_i,
  input  logic                jmp_i,
  input  logic                jr_i,
  input  logic [XLEN-1:0]     jr_addr_i,
  output logic [XLEN-1:0]     pc_o,
  output logic [XLEN-1:0]     seq_o,
  output logic [XLEN-1:0]     br_target_o,
  output logic [XLEN-1:0]     jmp_target_o,
  output logic [XLEN-1:0]     npc_o
);
  localparam int ALIGN    = 2;
  localparam int REGION_W = XLEN - JFIELD_W - ALIGN;

  logic [XLEN-1:0]           pc_q;
  logic [XLEN-1:0]           off_bytes;
  logic [JFIELD_W+ALIGN-1:0] jidx_bytes;

  npc_fields #(.XLEN(XLEN), .OFF_W(OFF_W), .JFIELD_W(JFIELD_W), .ALIGN(ALIGN)) u_fields (
    .instr_i      (instr_i),
    .off_bytes_o  (off_bytes),
    .jidx_bytes_o (jidx_bytes)
  );

  npc_targets #(.XLEN(XLEN), .JFIELD_W(JFIELD_W), .ALIGN(ALIGN)) u_targets (
    .pc_i         (pc_q),
    .off_bytes_i  (off_bytes),
    .jidx_bytes_i (jidx_bytes),
    .seq_o        (seq_o),
    .br_o         (br_target_o),
    .jmp_o        (jmp_target_o)
  );

  npc_select #(.XLEN(XLEN)) u_select (
    .jr_i      (jr_i),
    .jmp_i     (jmp_i),
    .br_i      (br_taken_i),
    .seq_i     (seq_o),
    .br_tgt_i  (br_target_o),
    .jmp_tgt_i (jmp_target_o),
    .reg_tgt_i (jr_addr_i),
    .npc_o     (npc_o)
  );

  always_ff @(posedge clk) begin
    if (rst)         pc_q <= RESET_VEC;
    else if (!stall) pc_q <= npc_o;
  end

  assign pc_o = pc_q;

  // R1: reset vector wins over stall and selects
  a_r1_reset_vec: assert property (@(posedge clk) rst |=> pc_q == RESET_VEC);
  // R6: PC follows the selected next address
  a_r6_advance: assert property (@(posedge clk) disable iff (rst)
    !stall |=> pc_q == $past(npc_o));
  // R7: stall holds the PC
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(pc_q));
  // R5: indirect jump has top priority
  a_r5_reg_first: assert property (@(posedge clk) disable iff (rst)
    jr_i |-> npc_o == jr_addr_i);
  // R5: direct jump beats a taken branch
  a_r5_jmp_second: assert property (@(posedge clk) disable iff (rst)
    (!jr_i && jmp_i) |-> npc_o == jmp_target_o);
  // R4: jump region comes from the incremented PC
  a_r4_region: assert property (@(posedge clk) disable iff (rst)
    jmp_target_o[XLEN-1 -: REGION_W] == seq_o[XLEN-1 -: REGION_W]);
  // R3: a zero offset field lands on the sequential address
  a_r3_zero_off: assert property (@(posedge clk) disable iff (rst)
    (instr_i[OFF_W-1:0] == '0) |-> br_target_o == seq_o);
endmodule

// File: tb/sim_next_pc_unit.sv
module sim_next_pc_unit;
  localparam logic [31:0] RV = 32'h0040_0000;
  localparam int NV = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [25:0] instr = '0;
  logic        br = 1'b0, jmp = 1'b0, jr = 1'b0;
  logic [31:0] jra = '0;
  logic [31:0] pc, seq, brt, jt, npc;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  next_pc_unit #(.RESET_VEC(RV)) u0 (
    .clk(clk), .rst(rst), .stall(stall), .instr_i(instr),
    .br_taken_i(br), .jmp_i(jmp), .jr_i(jr), .jr_addr_i(jra),
    .pc_o(pc), .seq_o(seq), .br_target_o(brt), .jmp_target_o(jt), .npc_o(npc)
  );

  // vector columns: starting PC, instruction low bits, {jr,jmp,br}, register address, expected next PC
  localparam logic [31:0] V_PC [NV] = '{
    32'h0040_0000, // R2 plain step
    32'hFFFF_FFFC, // R2 wrap
    32'h0040_0000, // R3 forward +3
    32'h0040_0100, // R3 minus one
    32'h0040_0100, // R3 most negative
    32'h0040_0100, // R3 most positive
    32'h0040_0000, // R3 branch not taken
    32'h0040_0000, // R4 jump in region 0
    32'h0FFF_FFFC, // R4 region crossing
    32'hA000_0000, // R4 high region
    32'h0040_0000, // R5 jump over branch
    32'h0040_0000, // R5 register over all
    32'h0040_0000  // R5 branch alone
  };
  localparam logic [25:0] V_IN [NV] = '{
    26'h0, 26'h0, 26'h0003, 26'hFFFF, 26'h8000, 26'h7FFF, 26'h0003,
    26'h0100008, 26'h3FFFFFF, 26'h0000001, 26'h0100008, 26'h0100008, 26'h0100008
  };
  localparam logic [2:0] V_CT [NV] = '{
    3'b000, 3'b000, 3'b001, 3'b001, 3'b001, 3'b001, 3'b000,
    3'b010, 3'b010, 3'b010, 3'b011, 3'b111, 3'b001
  };
  localparam logic [31:0] V_EXP [NV] = '{
    32'h0040_0004, 32'h0000_0000, 32'h0040_0010, 32'h0040_0100, 32'h003E_0104,
    32'h0042_0100, 32'h0040_0004, 32'h0040_0020, 32'h1FFF_FFFC, 32'hA000_0004,
    32'h0040_0020, 32'h1234_5678, 32'h0040_0024
  };
  localparam string V_RQ [NV] = '{
    "R2", "R2", "R3", "R3", "R3", "R3", "R3", "R4", "R4", "R4", "R5", "R5", "R5"
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic clear_in;
    jr = 1'b0; jmp = 1'b0; br = 1'b0; instr = '0; jra = '0;
  endtask

  task automatic load_pc(input logic [31:0] a);
    clear_in();
    jr = 1'b1; jra = a;
    tick();
    clear_in();
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    check("R1 reset", pc, RV);
    // R1: reset beats stall and an indirect jump
    stall = 1'b1; jr = 1'b1; jra = 32'hDEAD_BEE0;
    tick();
    check("R1 reset priority", pc, RV);
    stall = 1'b0; rst = 1'b0; clear_in();
    #1;
    check("R8 seq same cycle", seq, RV + 32'd4);
    tick();
    check("R6 sequential step", pc, RV + 32'd4);

    for (int i = 0; i < NV; i++) begin
      load_pc(V_PC[i]);
      instr = V_IN[i];
      {jr, jmp, br} = V_CT[i];
      jra = 32'h1234_5678;
      #1;
      check({V_RQ[i], " R8 npc"}, npc, V_EXP[i]);
      tick();
      check({V_RQ[i], " R6 pc"}, pc, V_EXP[i]);
    end

    // R7: stall holds PC while npc keeps the target
    load_pc(32'h0000_1000);
    stall = 1'b1; jmp = 1'b1; instr = 26'h0000040;
    tick();
    check("R7 hold 1", pc, 32'h0000_1000);
    check("R7 npc during stall", npc, 32'h0000_0100);
    tick();
    check("R7 hold 2", pc, 32'h0000_1000);
    stall = 1'b0;
    tick();
    check("R7 release", pc, 32'h0000_0100);

    // R1: reset mid-run
    rst = 1'b1;
    tick();
    check("R1 reset mid-run", pc, RV);
    rst = 1'b0; clear_in();
    #1;
    check("R4 jmp target after reset", jt, 32'h0000_0000);
    check("R3 br target after reset", brt, RV + 32'd4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule